// File: doc/BRIEF.md
# Shared Analog/Digital Pin Controller

This block governs a bank of shared pins. Each pin either feeds an analog input multiplexer or serves as a general-purpose digital line. A host reaches three byte-wide registers through a simple register bus: a mode register that picks analog or digital per pin, a direction register that picks input or output per pin, and a data register that holds the value to drive.

Out of reset every pin is analog and nothing is driven. Once a pin is switched to digital and set as an output, its latched data bit appears on the pad. A pin that stays analog ignores its direction and data bits, although the host can still load them in advance. A read of the data register returns the pad level after a two-flop synchroniser, not the value last written. The analog multiplexer stays connected to every present pin in either mode, so a conversion can still sample a pin that is driven digitally. A parameter selects an eight-pin or a four-pin build. In the narrow build the upper bits are inert.

Top module: `dualpin_ctrl`

## Requirements
- R1: After reset the mode register reads 0 (all analog), the direction register reads 1 for every present pin (all inputs), the data latch holds 0, and no pad is driven.
- R2: Register addresses are: 0 = mode, 1 = direction, 2 = data. A write with hostWrEn high loads the addressed register on the clock edge. A read returns the addressed register combinationally, and address 3 reads 0.
- R3: A pad is driven (padOutEn bit = 1) only when its mode bit is 1 (digital) and its direction bit is 0 (output). The change shows in the cycle after the write.
- R4: padOutVal carries the latched data bit for a driven pin (0 = low, 1 = high) and is 0 for a pin that is not driven.
- R5: While a pin is in analog mode, writes to its direction or data bit leave padOutEn and padOutVal unchanged.
- R6: Reading address 2 returns the pad input level. A change on padIn first becomes visible after the second rising clock edge, and the latched data value is never returned.
- R7: anaSelEn is 1 for every present pin in both modes.
- R8: In the four-pin build, bits 7 to 4 ignore writes, read as 0 from every address, and are 0 on padOutEn, padOutVal and anaSelEn.
- R9: A data value written while a pin is analog is kept, and it drives the pad once the pin becomes a digital output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 2 | Register select |
| hostWrEn | input | 1 | Write strobe |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Read data for hostAddr |
| padIn | input | 8 | Pad input levels (asynchronous) |
| padOutEn | output | 8 | Per-pin output-driver enable |
| padOutVal | output | 8 | Per-pin driven value |
| anaSelEn | output | 8 | Per-pin analog multiplexer connection |

## Verification
The bench loads direction and data while the pins are still analog. A design that decodes the two bits without the mode gate would drive the pads at this point, and one that drops the early data would drive the wrong level later. It reads the data register while the latch and the pads differ, which catches a readback of the latch. It also samples that readback one and two edges after a pad change, which exposes a missing or extra synchroniser stage. A four-pin build runs next to the eight-pin one, so leaking upper bits show on its outputs and readback.

// File: rtl/dualpin_pkg.sv
package dualpin_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MODE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrDir;
    logic    wrData;
    regSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/dualpin_ctrl_dec.sv
module dualpin_ctrl_dec
  import dualpin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  output strobe_t           strb
);
  regSel_e sel;

  always_comb begin
    sel         = regSel_e'(hostAddr);
    strb.rdSel  = sel;
    strb.wrMode = hostWrEn && (sel == SEL_MODE);
    strb.wrDir  = hostWrEn && (sel == SEL_DIR);
    strb.wrData = hostWrEn && (sel == SEL_DATA);
  end

  // R2: at most one register loads per cycle
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMode, strb.wrDir, strb.wrData}));
endmodule

// File: rtl/dualpin_datapath.sv
module dualpin_datapath
  import dualpin_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int PIN_COUNT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] hostWrData,
  input  logic [REG_W-1:0] padIn,
  output logic [REG_W-1:0] hostRdData,
  output logic [REG_W-1:0] padOutEn,
  output logic [REG_W-1:0] padOutVal,
  output logic [REG_W-1:0] anaSelEn
);
  localparam logic [REG_W-1:0] PIN_MASK = {REG_W{1'b1}} >> (REG_W - PIN_COUNT);

  logic [REG_W-1:0] modeQ, dirQ, dataQ, syncA, syncB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      dirQ  <= PIN_MASK;
      dataQ <= '0;
      syncA <= '0;
      syncB <= '0;
    end else begin
      if (strb.wrMode) modeQ <= hostWrData & PIN_MASK;
      if (strb.wrDir)  dirQ  <= hostWrData & PIN_MASK;
      if (strb.wrData) dataQ <= hostWrData & PIN_MASK;
      syncA <= padIn & PIN_MASK;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_pin
    if (i < PIN_COUNT) begin : g_live
      logic drive;
      assign drive        = modeQ[i] & ~dirQ[i];
      assign padOutEn[i]  = drive;
      assign padOutVal[i] = drive & dataQ[i];
      assign anaSelEn[i]  = 1'b1;
    end else begin : g_idle
      assign padOutEn[i]  = 1'b0;
      assign padOutVal[i] = 1'b0;
      assign anaSelEn[i]  = 1'b0;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_MODE: hostRdData = modeQ;
      SEL_DIR:  hostRdData = dirQ;
      SEL_DATA: hostRdData = syncB;
      default:  hostRdData = '0;
    endcase
  end

  // Cycles since reset, saturating; used only by the synchroniser check
  logic [1:0] ageQ;
  always_ff @(posedge clk) begin
    if (!rstN)              ageQ <= '0;
    else if (ageQ != 2'd2)  ageQ <= ageQ + 2'd1;
  end

  // R3: drive enables change only after a mode or direction write
  p_drive_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    (padOutEn != $past(padOutEn)) |-> $past(strb.wrMode || strb.wrDir));

  // R4: driven values change only after a register write
  p_val_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    (padOutVal != $past(padOutVal)) |-> $past(strb.wrMode || strb.wrDir || strb.wrData));

  // R5: dir/data writes with all pins analog leave the pads untouched
  p_analog_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.wrDir || strb.wrData) && !$past(strb.wrMode) && ($past(modeQ) == '0))
      |-> ($stable(padOutEn) && $stable(padOutVal)));

  // R6: readback of the pads lags padIn by exactly two edges
  p_sync_depth_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ageQ == 2'd2) |-> (syncB == ($past(padIn, 2) & PIN_MASK)));

  // R8: absent pins never drive and never read back
  p_upper_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((padOutEn | padOutVal | anaSelEn | hostRdData) & ~PIN_MASK) == '0);
endmodule

// File: rtl/dualpin_ctrl.sv
module dualpin_ctrl
  import dualpin_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int PIN_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [REG_W-1:0]  hostWrData,
  output logic [REG_W-1:0]  hostRdData,
  input  logic [REG_W-1:0]  padIn,
  output logic [REG_W-1:0]  padOutEn,
  output logic [REG_W-1:0]  padOutVal,
  output logic [REG_W-1:0]  anaSelEn
);
  strobe_t strb;

  dualpin_ctrl_dec u_dec (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn), .strb(strb)
  );

  dualpin_datapath #(.REG_W(REG_W), .PIN_COUNT(PIN_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData), .padIn(padIn),
    .hostRdData(hostRdData), .padOutEn(padOutEn), .padOutVal(padOutVal),
    .anaSelEn(anaSelEn)
  );
endmodule

// File: tb/dualpin_ctrl_tb_top.sv
module dualpin_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostAddr = '0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] padIn = '0;
  logic [7:0] rdW, enW, valW, anaW;
  logic [7:0] rdN, enN, valN, anaN;

  always #5 clk = ~clk;

  dualpin_ctrl #(.REG_W(8), .PIN_COUNT(8)) dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(rdW), .padIn(padIn),
    .padOutEn(enW), .padOutVal(valW), .anaSelEn(anaW)
  );

  dualpin_ctrl #(.REG_W(8), .PIN_COUNT(4)) dut_n (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(rdN), .padIn(padIn),
    .padOutEn(enN), .padOutVal(valN), .anaSelEn(anaN)
  );

  typedef struct {
    logic [7:0] act;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t scoreQ[$];
  int    nRun = 0;
  int    nFail = 0;
  bit    done = 0;

  task automatic push(input logic [7:0] act, input logic [7:0] exp, input string tag);
    item_t it;
    it.act = act; it.exp = exp; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] expW, input logic [7:0] expN,
                    input string tag);
    hostAddr = a;
    #1;
    push(rdW, expW, {tag, " wide rd"});
    push(rdN, expN, {tag, " narrow rd"});
  endtask

  task automatic pads(input logic [7:0] eW, input logic [7:0] vW,
                      input logic [7:0] eN, input logic [7:0] vN, input string tag);
    push(enW, eW, {tag, " wide en"});
    push(valW, vW, {tag, " wide val"});
    push(enN, eN, {tag, " narrow en"});
    push(valN, vN, {tag, " narrow val"});
  endtask

  // monitor: pops expected items and compares
  initial begin
    forever begin
      wait (scoreQ.size() > 0);
      begin
        item_t it;
        it = scoreQ.pop_front();
        nRun++;
        if (it.act !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, it.act, it.exp);
        end
      end
    end
  end

  task automatic finishRun();
    wait (scoreQ.size() == 0);
    #1;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state, R8 narrow reset
    rd(2'd0, 8'h00, 8'h00, "R1 mode reset");
    rd(2'd1, 8'hFF, 8'h0F, "R1 dir reset / R8");
    pads(8'h00, 8'h00, 8'h00, 8'h00, "R1 reset pads");
    push(anaW, 8'hFF, "R7 wide ana");
    push(anaN, 8'h0F, "R7/R8 narrow ana");

    // R5: dir/data written while analog
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    pads(8'h00, 8'h00, 8'h00, 8'h00, "R5 analog ignores dir/data");
    rd(2'd1, 8'h00, 8'h00, "R2 dir readback");
    rd(2'd2, 8'h00, 8'h00, "R6 data reads pads not latch");

    // R3 / R9: switch low pins digital, latched data appears
    wr(2'd0, 8'h0F);
    pads(8'h0F, 8'h0F, 8'h0F, 8'h0F, "R3 R9 digital outputs");
    wr(2'd2, 8'h05);
    pads(8'h0F, 8'h05, 8'h0F, 8'h05, "R4 data drives");
    wr(2'd1, 8'h03);
    pads(8'h0C, 8'h04, 8'h0C, 8'h04, "R3 R4 inputs undriven");
    rd(2'd0, 8'h0F, 8'h0F, "R2 mode readback");
    rd(2'd3, 8'h00, 8'h00, "R2 reserved reads 0");

    // R6: synchroniser latency
    @(negedge clk);
    padIn = 8'hA5;
    hostAddr = 2'd2;
    @(negedge clk);
    rd(2'd2, 8'h00, 8'h00, "R6 one edge old");
    @(negedge clk);
    rd(2'd2, 8'hA5, 8'h05, "R6 two edges new / R8");

    // R8: upper bits ignored in narrow build
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'hFF, 8'h0F, "R8 mode upper bits");
    pads(8'hFC, 8'h04, 8'h0C, 8'h04, "R8 all digital");
    push(anaW, 8'hFF, "R7 ana in digital mode");
    push(anaN, 8'h0F, "R7 narrow ana digital");

    // back to analog: nothing driven, data latch kept
    wr(2'd0, 8'h00);
    pads(8'h00, 8'h00, 8'h00, 8'h00, "R3 analog releases pads");
    wr(2'd1, 8'hF0);
    pads(8'h00, 8'h00, 8'h00, 8'h00, "R5 dir write while analog");
    wr(2'd0, 8'h0F);
    pads(8'h0F, 8'h05, 8'h0F, 8'h05, "R9 data kept across modes");

    finishRun();
  end
endmodule